// File: doc/BRIEF.md
# Composite Score Maximizer

The block turns a frame's base scores into composite scores. Before it is started, a score RAM holds one signed base score in each of the entries `0 .. NBASE-1`. For each composite it walks a short list of base-score addresses and reads each of those scores from the RAM. It keeps the largest one and writes it into that composite's own slot, which sits directly above the last base entry. Two constant tables, both given as parameters, drive the walk. The length table holds the number of members for each composite. The member table holds the RAM addresses of all members, packed one composite after another.

A walker holds a count loaded from the length table and a running offset into the member table. The member table index is the offset plus the count minus one. The count is decremented after each read, so the members of a composite are visited from its last table entry down to its first. When the count reaches zero, the best score goes out to the RAM and the next composite's length is loaded. When every composite has been written, a done flag goes up. Outside this short active window the registers are held by their enables. Each read is followed by one wait cycle while the RAM returns its data.

Top module: `cmx_top`

## Requirements
- R1: While reset is asserted and after reset is released, `done`, `ram_rd` and `ram_wr` are low until a start is accepted.
- R2: For composite k, the block issues exactly one single-cycle read for each member address listed for k. `ram_rd` is never high in two consecutive cycles, because each read is followed by a one-cycle wait for data that arrives one cycle after the read.
- R3: The value written for a composite is the maximum of its members' scores, compared as signed two's-complement numbers of `SW` bits.
- R4: The slot for composite k is at RAM address `NBASE + k`. The slots are written once each, in increasing k order. No address below `NBASE` is ever written.
- R5: A composite with a member count of zero has the most negative value, `-2^(SW-1)`, written to its slot.
- R6: If a composite's members tie, or all of its members hold the most negative value, that common value is written.
- R7: `done` rises in the cycle after the last slot write and stays high until the next accepted start. From the edge that accepts start to the edge that raises `done`, the block takes `sum over k of (2 + 2*count_k)` clock cycles.
- R8: A start pulse is ignored while a pass is in progress. It neither restarts nor changes the writes of that pass.
- R9: `ram_rd` and `ram_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins a pass over all composites when the block is idle |
| ram_addr | output | AW | Score RAM address for a read or a write |
| ram_rd | output | 1 | Read strobe; data is expected on `ram_rdata` one cycle later |
| ram_rdata | input | SW | Signed score returned by the RAM |
| ram_wr | output | 1 | Write strobe for a composite slot |
| ram_wdata | output | SW | Signed best score being written |
| done | output | 1 | High once all composite slots are written |

## Verification
Two events can fall on the same clock edge: a new start request, and the walker's own step to the next composite or its final slot write. The bench pulses start in the middle of a pass, on an edge where the walker is reading a member. It judges the outcome by the write stream and the completion time. The pass must still write every slot exactly once and in order, with the maxima expected from the original pass. `done` must rise on the cycle predicted from the list lengths, with no restart.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_LOAD,
    W_READ,
    W_TAKE,
    W_STORE
  } walk_state_t;

endpackage

// File: rtl/cmx_rom.sv
module cmx_rom #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter logic [DEPTH*W-1:0] CONTENT = '0
) (
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(idx) == i) data = CONTENT[i*W +: W];
    end
  end

endmodule

// File: rtl/cmx_walker.sv
module cmx_walker
  import cmx_pkg::*;
#(
  parameter int SW    = 16,
  parameter int NBASE = 16,
  parameter int NCOMP = 4,
  parameter int CW    = 3,
  parameter int AW    = 5,
  parameter int CIW   = 2,
  parameter int MIX   = 3,
  parameter int MIW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic [CIW-1:0]       cnt_idx,
  input  logic [CW-1:0]        cnt_val,
  output logic [MIX-1:0]       mem_idx,
  input  logic [AW-1:0]        mem_addr,
  output logic [AW-1:0]        ram_addr,
  output logic                 ram_rd,
  input  logic signed [SW-1:0] ram_rdata,
  output logic                 ram_wr,
  output logic signed [SW-1:0] ram_wdata,
  output logic                 done
);

  localparam logic signed [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [AW-1:0]        SLOT0    = AW'(NBASE);
  localparam logic [CIW-1:0]       LASTC    = CIW'(NCOMP-1);

  walk_state_t          st, st_n;
  logic [CIW-1:0]       comp, comp_n;
  logic [MIW-1:0]       base, base_n;
  logic [CW-1:0]        cnt, cnt_n;
  logic signed [SW-1:0] best, best_n;
  logic                 done_n;
  logic                 run_en;
  logic [31:0]          idx_sum;

  assign cnt_idx = comp;
  assign idx_sum = 32'(base) + 32'(cnt) - 32'd1;
  assign mem_idx = idx_sum[MIX-1:0];
  assign run_en  = (st != W_IDLE) || start;

  always_comb begin
    st_n      = st;
    comp_n    = comp;
    base_n    = base;
    cnt_n     = cnt;
    best_n    = best;
    done_n    = done;
    ram_addr  = '0;
    ram_rd    = 1'b0;
    ram_wr    = 1'b0;
    ram_wdata = best;
    unique case (st)
      W_IDLE: begin
        if (start) begin
          comp_n = '0;
          base_n = '0;
          done_n = 1'b0;
          st_n   = W_LOAD;
        end
      end
      W_LOAD: begin
        cnt_n  = cnt_val;
        best_n = MOST_NEG;
        st_n   = (cnt_val == '0) ? W_STORE : W_READ;
      end
      W_READ: begin
        ram_rd   = 1'b1;
        ram_addr = mem_addr;
        cnt_n    = cnt - 1'b1;
        st_n     = W_TAKE;
      end
      W_TAKE: begin
        if (ram_rdata > best) best_n = ram_rdata;
        st_n = (cnt == '0) ? W_STORE : W_READ;
      end
      W_STORE: begin
        ram_wr   = 1'b1;
        ram_addr = SLOT0 + AW'(comp);
        base_n   = base + MIW'(cnt_val);
        if (comp == LASTC) begin
          done_n = 1'b1;
          st_n   = W_IDLE;
        end else begin
          comp_n = comp + 1'b1;
          st_n   = W_LOAD;
        end
      end
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      comp <= '0;
      base <= '0;
      cnt  <= '0;
      best <= MOST_NEG;
      done <= 1'b0;
    end else if (run_en) begin
      st   <= st_n;
      comp <= comp_n;
      base <= base_n;
      cnt  <= cnt_n;
      best <= best_n;
      done <= done_n;
    end
  end

  // R9
  no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ram_wr));

  // R2
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> !ram_rd);

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> (int'(ram_addr) >= NBASE && int'(ram_addr) < NBASE + NCOMP));

  // R7
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ram_wr));

  // R3
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_TAKE) |=> (best >= $past(best)));

endmodule

// File: rtl/cmx_top.sv
module cmx_top #(
  parameter int SW    = 16,
  parameter int NBASE = 16,
  parameter int NCOMP = 4,
  parameter int NMEM  = 8,
  parameter int CW    = 3,
  parameter int AW    = $clog2(NBASE + NCOMP),
  parameter logic [NCOMP*CW-1:0] CNT_TABLE = {3'd4, 3'd0, 3'd1, 3'd3},
  parameter logic [NMEM*AW-1:0]  ADDR_TABLE =
    {5'd3, 5'd9, 5'd15, 5'd0, 5'd5, 5'd11, 5'd7, 5'd2}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic [AW-1:0]        ram_addr,
  output logic                 ram_rd,
  input  logic signed [SW-1:0] ram_rdata,
  output logic                 ram_wr,
  output logic signed [SW-1:0] ram_wdata,
  output logic                 done
);

  localparam int CIW = (NCOMP > 1) ? $clog2(NCOMP) : 1;
  localparam int MIX = (NMEM > 1) ? $clog2(NMEM) : 1;
  localparam int MIW = $clog2(NMEM + 1) + 1;

  logic [1:0]     rst_sync;
  logic           rst_core_n;
  logic [CIW-1:0] cnt_idx;
  logic [CW-1:0]  cnt_val;
  logic [MIX-1:0] mem_idx;
  logic [AW-1:0]  mem_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  cmx_rom #(.W(CW), .DEPTH(NCOMP), .IW(CIW), .CONTENT(CNT_TABLE)) u_len_rom (
    .idx  (cnt_idx),
    .data (cnt_val)
  );

  cmx_rom #(.W(AW), .DEPTH(NMEM), .IW(MIX), .CONTENT(ADDR_TABLE)) u_mbr_rom (
    .idx  (mem_idx),
    .data (mem_addr)
  );

  cmx_walker #(
    .SW(SW), .NBASE(NBASE), .NCOMP(NCOMP), .CW(CW),
    .AW(AW), .CIW(CIW), .MIX(MIX), .MIW(MIW)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .cnt_idx   (cnt_idx),
    .cnt_val   (cnt_val),
    .mem_idx   (mem_idx),
    .mem_addr  (mem_addr),
    .ram_addr  (ram_addr),
    .ram_rd    (ram_rd),
    .ram_rdata (ram_rdata),
    .ram_wr    (ram_wr),
    .ram_wdata (ram_wdata),
    .done      (done)
  );

endmodule

// File: tb/cmx_top_test.sv
module cmx_top_test;

  localparam int NB = 16;
  localparam int NC = 4;
  localparam int DEP = NB + NC;
  localparam logic signed [15:0] NEG = 16'sh8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] ram_addr;
  logic ram_rd, ram_wr, done;
  logic signed [15:0] ram_rdata = '0;
  logic signed [15:0] ram_wdata;

  logic signed [15:0] mem [DEP];
  logic signed [15:0] shadow [NB];
  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, cyc = 0;

  int lst_cnt [NC] = '{3, 1, 0, 4};
  int lst_adr [8]  = '{2, 7, 11, 5, 0, 15, 9, 3};

  always #4 clk = ~clk;

  cmx_top uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_rdata(ram_rdata),
    .ram_wr(ram_wr), .ram_wdata(ram_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // RAM model with one-cycle read latency; write order checked here (R4)
  always @(posedge clk) begin
    cyc++;
    if (ram_rd) begin
      ram_rdata <= mem[ram_addr];
      rd_cnt++;
    end
    if (ram_wr) begin
      chk(int'(ram_addr) == NB + wr_cnt, "R4 slot order", int'(ram_addr), NB + wr_cnt);
      mem[ram_addr] <= ram_wdata;
      wr_cnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_slot(input int k);
    int ofs = 0;
    int m = -32768;
    for (int j = 0; j < k; j++) ofs += lst_cnt[j];
    for (int j = 0; j < lst_cnt[k]; j++)
      if (int'(mem[lst_adr[ofs + j]]) > m) m = int'(mem[lst_adr[ofs + j]]);
    return m;
  endfunction

  function automatic int exp_cycles();
    int s = 0;
    for (int k = 0; k < NC; k++) s += 2 + 2 * lst_cnt[k];
    return s;
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < NB; i++) begin
      case (mode)
        0: mem[i] = 16'(i * 100 - 700);
        1: mem[i] = NEG;
        2: mem[i] = (i == 9) ? 16'sd32767 : 16'sd42;
        default: mem[i] = 16'(-(i * 37) - 5);
      endcase
      shadow[i] = mem[i];
    end
    for (int i = NB; i < DEP; i++) mem[i] = 16'sd1234;
  endtask

  task automatic run_pass(input string tag, input int poke_at);
    int n = 0;
    int expv [NC];
    for (int k = 0; k < NC; k++) expv[k] = exp_slot(k);
    wr_cnt = 0;
    rd_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    chk(done == 1'b0, {"R7 done cleared ", tag}, int'(done), 0);
    while (!done && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == poke_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(n == exp_cycles(), {"R7 latency ", tag}, n, exp_cycles());
    chk(wr_cnt == NC, {"R4 write count ", tag}, wr_cnt, NC);
    chk(rd_cnt == 8, {"R2 read count ", tag}, rd_cnt, 8);
    for (int k = 0; k < NC; k++)
      chk(int'(mem[NB + k]) == expv[k], {"R3 slot value ", tag}, int'(mem[NB + k]), expv[k]);
    chk(mem[NB + 2] == NEG, {"R5 empty composite ", tag}, int'(mem[NB + 2]), -32768);
    for (int i = 0; i < NB; i++)
      chk(mem[i] == shadow[i], {"R4 base untouched ", tag}, int'(mem[i]), int'(shadow[i]));
    repeat (3) @(negedge clk);
    chk(done == 1'b1, {"R7 done holds ", tag}, int'(done), 1);
  endtask

  task automatic t_reset();
    #1;
    chk(done == 1'b0 && ram_rd == 1'b0 && ram_wr == 1'b0, "R1 in reset",
        int'({done, ram_rd, ram_wr}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(done == 1'b0 && ram_rd == 1'b0 && ram_wr == 1'b0, "R1 after reset",
        int'({done, ram_rd, ram_wr}), 0);
  endtask

  task automatic t_distinct();
    fill(0);
    run_pass("distinct", 0);
  endtask

  task automatic t_all_neg();
    fill(1);
    run_pass("R6 all most-negative", 0);
    chk(mem[NB] == NEG, "R6 min member", int'(mem[NB]), -32768);
  endtask

  task automatic t_ties();
    fill(2);
    run_pass("R6 ties", 0);
    chk(int'(mem[NB + 1]) == 42, "R6 tie value", int'(mem[NB + 1]), 42);
    chk(int'(mem[NB + 3]) == 32767, "R3 top positive", int'(mem[NB + 3]), 32767);
  endtask

  task automatic t_busy_start();
    fill(3);
    run_pass("R8 start while busy", 5);
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) mem[i] = '0;
    t_reset();
    t_distinct();
    t_all_neg();
    t_ties();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule